// File: doc/BRIEF.md
# Pin Function Mailbox with Acknowledge

This block is the register window that several processor requesters share to talk to one pin function. It holds a mode word, two parameter words (X and Y), a result word (Z) and a single event flag. Requesters present commands on a valid/ready handshake. A fixed-priority arbiter serves exactly one of them per cycle. Read commands return Z and the flag on a shared response port, tagged with the index of the requester.

The event flag marks that the pin function has something new. The pin function raises it, and only an acknowledge lowers it. Every write carries an implicit acknowledge, and so does the ordinary read. A second read form, the quiet read, returns the same data but leaves the flag alone. A requester can then watch the pin while another one is writing parameters, and its reads do not swallow events. Here the pin function is a stub driven from the ports: a strobe loads Z and raises the flag.

Top module: `pinmbx_top`

## Requirements
- R1: After a synchronous reset, mode, X and Y read as zero, the event flag is low and no response is valid.
- R2: Commands use a 3-bit code per requester: 1 writes mode, 2 writes X, 3 writes Y, 4 is the acknowledging read, 5 is the quiet read. Codes 0, 6 and 7 are accepted but change no register, leave the flag as it is and produce no response.
- R3: An accepted write loads its data word into the addressed register, visible on its output in the cycle after acceptance.
- R4: Each of the three writes clears the event flag in the cycle after acceptance.
- R5: An acknowledging read gives, in the cycle after acceptance, a valid response carrying Z and the flag as they were in the accepting cycle, and clears the flag.
- R6: A quiet read returns the same response as R5 but leaves the flag unchanged.
- R7: An event strobe raises the flag in the next cycle. The flag then stays high until an acknowledge.
- R8: When an event strobe and an acknowledge fall in the same cycle, the flag ends up high.
- R9: Among requesters that are valid in the same cycle, the lowest index is the only one with ready high. The others hold their request and are served in later cycles.
- R10: The response carries the index of the requester whose read produced it, and writes produce no response.
- R11: An event strobe loads its value into Z, and later reads return that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Request valid, one bit per requester |
| req_cmd | input | 3*NREQ | Command codes, requester i in bits [3i+2:3i] |
| req_data | input | DW*NREQ | Write data, requester i in bits [DW*i+DW-1:DW*i] |
| req_ready | output | NREQ | Grant; a command is taken when valid and ready are both high |
| ev_strobe | input | 1 | Pin function stub: load Z and raise the flag |
| ev_value | input | DW | Pin function stub: value for Z |
| mode_q | output | DW | Mode register |
| x_q | output | DW | Parameter X register |
| y_q | output | DW | Parameter Y register |
| evt_flag | output | 1 | Event flag |
| resp_valid | output | 1 | Read response valid |
| resp_id | output | IDW | Index of the requester that issued the read |
| resp_data | output | DW | Z at acceptance |
| resp_flag | output | 1 | Flag at acceptance |

## Verification
Every result is due exactly one clock edge after the command or strobe that causes it. Register outputs, the flag and the read response all update at the edge that accepts the command. req_ready is combinational from req_valid and holds in the same cycle. The bench drives inputs on the falling edge and checks ready shortly after it drives. It checks registered results at the next falling edge, then again one cycle later where a result must hold or end, such as the response dropping and the flag staying high. In the collision case the bench expects the pre-edge flag and Z in the response and the raised flag afterwards.

// File: rtl/pinmbx_pkg.sv
package pinmbx_pkg;

    localparam int CMD_W = 3;

    localparam logic [CMD_W-1:0] CMD_NOP      = 3'd0;
    localparam logic [CMD_W-1:0] CMD_SET_MODE = 3'd1;
    localparam logic [CMD_W-1:0] CMD_SET_X    = 3'd2;
    localparam logic [CMD_W-1:0] CMD_SET_Y    = 3'd3;
    localparam logic [CMD_W-1:0] CMD_RD_ACK   = 3'd4;
    localparam logic [CMD_W-1:0] CMD_RD_QUIET = 3'd5;

    typedef struct packed {
        logic wr_mode;
        logic wr_x;
        logic wr_y;
        logic rd;
        logic ack;
    } op_t;

    function automatic op_t decode_cmd(logic [CMD_W-1:0] c);
        op_t o;
        o = '0;
        case (c)
            CMD_SET_MODE: begin o.wr_mode = 1'b1; o.ack = 1'b1; end
            CMD_SET_X:    begin o.wr_x    = 1'b1; o.ack = 1'b1; end
            CMD_SET_Y:    begin o.wr_y    = 1'b1; o.ack = 1'b1; end
            CMD_RD_ACK:   begin o.rd      = 1'b1; o.ack = 1'b1; end
            CMD_RD_QUIET: begin o.rd      = 1'b1; end
            default:      o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/pinmbx_arb.sv
module pinmbx_arb #(
    parameter int N = 3,
    localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   req,
    output logic [N-1:0]   grant,
    output logic [IDW-1:0] gid,
    output logic           any
);
    always_comb begin
        grant = '0;
        gid   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                gid      = IDW'(i);
            end
        end
        any = |req;
    end

    always_comb begin
        // R9
        arb_onehot_chk: assert ($onehot0(grant));
        // R9
        arb_any_chk: assert ((grant != '0) == (req != '0));
    end
endmodule

// File: rtl/pinmbx_fnstub.sv
module pinmbx_fnstub #(
    parameter int DW = 32
) (
    input  logic          ev_strobe,
    input  logic [DW-1:0] ev_value,
    output logic          fn_set,
    output logic          fn_load,
    output logic [DW-1:0] fn_z
);
    always_comb begin
        fn_set  = ev_strobe;
        fn_load = ev_strobe;
        fn_z    = ev_value;
    end
endmodule

// File: rtl/pinmbx_regs.sv
module pinmbx_regs #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_mode,
    input  logic          wr_x,
    input  logic          wr_y,
    input  logic          ack,
    input  logic [DW-1:0] wdata,
    input  logic          fn_set,
    input  logic          fn_load,
    input  logic [DW-1:0] fn_z,
    output logic [DW-1:0] mode_q,
    output logic [DW-1:0] x_q,
    output logic [DW-1:0] y_q,
    output logic [DW-1:0] z_q,
    output logic          flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_mode) mode_q <= wdata;
            if (wr_x)    x_q    <= wdata;
            if (wr_y)    y_q    <= wdata;
            if (fn_load) z_q    <= fn_z;
            if (fn_set)      flag_q <= 1'b1;
            else if (ack)    flag_q <= 1'b0;
        end
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        fn_set |=> flag_q);
    // R4
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !fn_set) |=> !flag_q);
    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !ack) |=> flag_q);
endmodule

// File: rtl/pinmbx_top.sv
module pinmbx_top
    import pinmbx_pkg::*;
#(
    parameter int NREQ = 3,
    parameter int DW   = 32,
    localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NREQ-1:0]       req_valid,
    input  logic [NREQ*CMD_W-1:0] req_cmd,
    input  logic [NREQ*DW-1:0]    req_data,
    output logic [NREQ-1:0]       req_ready,
    input  logic                  ev_strobe,
    input  logic [DW-1:0]         ev_value,
    output logic [DW-1:0]         mode_q,
    output logic [DW-1:0]         x_q,
    output logic [DW-1:0]         y_q,
    output logic                  evt_flag,
    output logic                  resp_valid,
    output logic [IDW-1:0]        resp_id,
    output logic [DW-1:0]         resp_data,
    output logic                  resp_flag
);
    logic [NREQ-1:0] grant;
    logic [IDW-1:0]  gid;
    logic            any;
    logic [CMD_W-1:0] cmd_unp [NREQ];
    logic [DW-1:0]    dat_unp [NREQ];
    logic [CMD_W-1:0] sel_cmd;
    logic [DW-1:0]    sel_data;
    op_t              op;
    logic             fn_set, fn_load;
    logic [DW-1:0]    fn_z;
    logic [DW-1:0]    z_q;

    genvar g;
    generate
        for (g = 0; g < NREQ; g++) begin : g_unpack
            assign cmd_unp[g] = req_cmd[g*CMD_W +: CMD_W];
            assign dat_unp[g] = req_data[g*DW +: DW];
        end
    endgenerate

    pinmbx_arb #(.N(NREQ)) u_arb (
        .req   (req_valid),
        .grant (grant),
        .gid   (gid),
        .any   (any)
    );

    assign req_ready = grant;

    always_comb begin
        sel_cmd  = '0;
        sel_data = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (grant[i]) begin
                sel_cmd  = sel_cmd  | cmd_unp[i];
                sel_data = sel_data | dat_unp[i];
            end
        end
        op = any ? decode_cmd(sel_cmd) : '0;
    end

    pinmbx_fnstub #(.DW(DW)) u_stub (
        .ev_strobe (ev_strobe),
        .ev_value  (ev_value),
        .fn_set    (fn_set),
        .fn_load   (fn_load),
        .fn_z      (fn_z)
    );

    pinmbx_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_mode (op.wr_mode),
        .wr_x    (op.wr_x),
        .wr_y    (op.wr_y),
        .ack     (op.ack),
        .wdata   (sel_data),
        .fn_set  (fn_set),
        .fn_load (fn_load),
        .fn_z    (fn_z),
        .mode_q  (mode_q),
        .x_q     (x_q),
        .y_q     (y_q),
        .z_q     (z_q),
        .flag_q  (evt_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_id    <= '0;
            resp_data  <= '0;
            resp_flag  <= 1'b0;
        end else begin
            resp_valid <= op.rd;
            if (op.rd) begin
                resp_id   <= gid;
                resp_data <= z_q;
                resp_flag <= evt_flag;
            end
        end
    end

    // R6
    quiet_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op.rd && !op.ack && !ev_strobe) |=> (evt_flag == $past(evt_flag)));
    // R10
    resp_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (any && !op.rd) |=> !resp_valid);
    // R2
    ignore_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (any && op == '0) |=> ($stable(mode_q) && $stable(x_q) && $stable(y_q)));
endmodule

// File: tb/tb_pinmbx_top.sv
`timescale 1ns/1ps
module tb_pinmbx_top;
    localparam int NREQ = 3;
    localparam int DW   = 32;
    localparam int IDW  = 2;

    logic                  clk = 1'b0;
    logic                  rst;
    logic [NREQ-1:0]       req_valid;
    logic [NREQ*3-1:0]     req_cmd;
    logic [NREQ*DW-1:0]    req_data;
    logic [NREQ-1:0]       req_ready;
    logic                  ev_strobe;
    logic [DW-1:0]         ev_value;
    logic [DW-1:0]         mode_q, x_q, y_q;
    logic                  evt_flag;
    logic                  resp_valid;
    logic [IDW-1:0]        resp_id;
    logic [DW-1:0]         resp_data;
    logic                  resp_flag;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pinmbx_top #(.NREQ(NREQ), .DW(DW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_data(req_data), .req_ready(req_ready), .ev_strobe(ev_strobe),
        .ev_value(ev_value), .mode_q(mode_q), .x_q(x_q), .y_q(y_q),
        .evt_flag(evt_flag), .resp_valid(resp_valid), .resp_id(resp_id),
        .resp_data(resp_data), .resp_flag(resp_flag)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(int idx, logic [2:0] c, logic [DW-1:0] d);
        req_valid[idx]          = 1'b1;
        req_cmd[idx*3 +: 3]     = c;
        req_data[idx*DW +: DW]  = d;
    endtask

    task automatic release_req(int idx);
        req_valid[idx] = 1'b0;
    endtask

    task automatic idle_all();
        req_valid = '0;
        req_cmd   = '0;
        req_data  = '0;
        ev_strobe = 1'b0;
    endtask

    // one command, alone, accepted at the next edge; back at a negedge after it
    task automatic do_cmd(int idx, logic [2:0] c, logic [DW-1:0] d);
        drive(idx, c, d);
        @(negedge clk);
        idle_all();
    endtask

    task automatic pulse(logic [DW-1:0] v);
        ev_strobe = 1'b1;
        ev_value  = v;
        @(negedge clk);
        ev_strobe = 1'b0;
        check("R7 flag raised by strobe", evt_flag, 1);
    endtask

    task automatic t_reset();
        check("R1 mode reset", mode_q, 0);
        check("R1 x reset", x_q, 0);
        check("R1 y reset", y_q, 0);
        check("R1 flag reset", evt_flag, 0);
        check("R1 resp reset", resp_valid, 0);
    endtask

    task automatic t_writes();
        pulse(32'h11);
        do_cmd(0, 3'd1, 32'hA5);
        check("R3 mode write", mode_q, 32'hA5);
        check("R4 mode write acks", evt_flag, 0);
        check("R10 write gives no response", resp_valid, 0);
        pulse(32'h12);
        do_cmd(1, 3'd2, 32'h1234_5678);
        check("R3 x write", x_q, 32'h1234_5678);
        check("R4 x write acks", evt_flag, 0);
        pulse(32'h13);
        do_cmd(2, 3'd3, 32'hDEAD);
        check("R3 y write", y_q, 32'hDEAD);
        check("R4 y write acks", evt_flag, 0);
    endtask

    task automatic t_read_ack();
        pulse(32'hCAFE);
        do_cmd(1, 3'd4, 0);
        check("R5 resp valid", resp_valid, 1);
        check("R11 resp data is Z", resp_data, 32'hCAFE);
        check("R5 resp flag", resp_flag, 1);
        check("R10 resp id", resp_id, 1);
        check("R5 flag cleared", evt_flag, 0);
        @(negedge clk);
        check("R5 resp single cycle", resp_valid, 0);
        do_cmd(0, 3'd4, 0);
        check("R5 second read flag", resp_flag, 0);
        check("R11 Z held", resp_data, 32'hCAFE);
        check("R10 resp id 0", resp_id, 0);
    endtask

    task automatic t_read_quiet();
        pulse(32'hBEEF);
        do_cmd(2, 3'd5, 0);
        check("R6 resp valid", resp_valid, 1);
        check("R6 resp data", resp_data, 32'hBEEF);
        check("R6 resp flag", resp_flag, 1);
        check("R10 resp id 2", resp_id, 2);
        check("R6 flag kept", evt_flag, 1);
        do_cmd(0, 3'd5, 0);
        check("R6 repeat flag", resp_flag, 1);
        check("R6 flag still kept", evt_flag, 1);
        repeat (5) @(negedge clk);
        check("R7 flag sticky", evt_flag, 1);
        do_cmd(1, 3'd4, 0);
        check("R5 ack after quiet", evt_flag, 0);
    endtask

    task automatic t_collide();
        ev_strobe = 1'b1;
        ev_value  = 32'h77;
        drive(0, 3'd4, 0);
        @(negedge clk);
        idle_all();
        check("R8 set wins", evt_flag, 1);
        check("R8 resp flag pre-edge", resp_flag, 0);
        check("R8 resp data old Z", resp_data, 32'hBEEF);
        do_cmd(2, 3'd5, 0);
        check("R11 new Z", resp_data, 32'h77);
    endtask

    task automatic t_prio();
        drive(0, 3'd2, 32'h100);
        drive(2, 3'd4, 0);
        #1;
        check("R9 lowest ready", req_ready, 3'b001);
        @(negedge clk);
        release_req(0);
        check("R9 winner write done", x_q, 32'h100);
        check("R10 no resp for write", resp_valid, 0);
        #1;
        check("R9 waiter ready", req_ready, 3'b100);
        @(negedge clk);
        idle_all();
        check("R9 waiter served", resp_valid, 1);
        check("R10 waiter id", resp_id, 2);
        drive(1, 3'd3, 32'h5);
        drive(2, 3'd3, 32'h6);
        #1;
        check("R9 ready 1 over 2", req_ready, 3'b010);
        @(negedge clk);
        release_req(1);
        check("R9 first y", y_q, 32'h5);
        @(negedge clk);
        idle_all();
        check("R9 second y", y_q, 32'h6);
    endtask

    task automatic t_ignored();
        pulse(32'h99);
        do_cmd(0, 3'd6, 32'hFFFF);
        check("R2 code6 resp", resp_valid, 0);
        do_cmd(1, 3'd0, 32'hFFFF);
        do_cmd(2, 3'd7, 32'hFFFF);
        check("R2 mode kept", mode_q, 32'hA5);
        check("R2 x kept", x_q, 32'h100);
        check("R2 y kept", y_q, 32'h6);
        check("R2 flag kept", evt_flag, 1);
        check("R2 no resp", resp_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog all requirements act=timeout exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        ev_value = '0;
        idle_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_writes();
        t_read_ack();
        t_read_quiet();
        t_collide();
        t_prio();
        t_ignored();
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule